// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a watchdog timer reached over a small word-wide register bus. A 32-bit counter counts down while enabled, either once per bus clock or once per 1 MHz tick. The tick comes from an internal prescaler that divides the system clock. Software keeps the system alive by writing one exact key word to the restart register. That write copies the programmed reload value into the counter. Any other value written there is dropped.

If the enabled counter steps while it already holds zero, the block records an expiry and reloads the counter. At the same time it starts the actions that the control register selects: an interrupt, an external pulse, and a reset. The reset goes either to the SoC alone or to the whole chip. Each selected action stays high for a fixed, parameterised number of cycles.

A typical sequence is: clear control, write the reload value, write the key, then set control with enable and the wanted actions. Writing a new reload value alone never disturbs a running count.

Top module: `wdog_timer`

## Requirements
- R1: Reads decode busAddr[3:2]. 0 returns the live count. 1 returns the reload value. 2 (restart) returns zero. 3 returns the control value in bits 5:0 with zeros above. busRdata follows busAddr combinationally.
- R2: A write of exactly 32'h0000_4755 to word 2 loads the reload value into the counter at that clock edge. This load takes priority over a count step in the same cycle.
- R3: A write of any other value to word 2 has no effect on the counter.
- R4: A write to word 1 changes only the reload value. The running count is unchanged until the next keyed restart or expiry.
- R5: Control bit 0 enables stepping. While it is clear, the counter holds its value.
- R6: Control bit 4 clear makes the counter step on every clock. Set, the counter steps only on prescaler ticks. The prescaler is a free-running divide-by-(CLK_HZ/TICK_HZ) counter, cleared by reset, whose tick is high in the last cycle of each period.
- R7: A step taken while the count is zero is an expiry. The counter loads the reload value instead of wrapping.
- R8: On expiry, the outputs selected by control bit 2 (interrupt), bit 3 (external pulse) and bit 1 (reset) rise on the next cycle and stay high for PULSE_CYCLES cycles. The selection is latched at the expiry. A new expiry restarts the window.
- R9: Control bit 5 picks the reset target: 0 drives socResetOut, 1 drives chipResetOut. The two are never high together.
- R10: After reset, every register, the count and every output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access valid |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Byte address; bits 3:2 select the word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| irqOut | output | 1 | Expiry interrupt window |
| extPulseOut | output | 1 | Expiry external pulse window |
| socResetOut | output | 1 | SoC-only reset window |
| chipResetOut | output | 1 | Full-chip reset window |

## Verification
The count is driven with several patterns. A run with bus-clock stepping shows that expiry fires on a zero count and reloads instead of wrapping. Prescaled stepping with the chip scope selected separates the two tick sources and the two reset targets. A sequence of keyed restarts spaced more closely than the timeout must keep every action output low. Wrong-key writes, reload-only writes and disabled periods sit between these runs, so a counter that reacts to them shows up against the reference model at once.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int REG_W = 32;
  localparam logic [REG_W-1:0] RESTART_KEY = 32'h0000_4755;

  typedef enum logic [1:0] {
    REG_STATUS  = 2'd0,
    REG_RELOAD  = 2'd1,
    REG_RESTART = 2'd2,
    REG_CTRL    = 2'd3
  } reg_sel_e;

  // bit 5 .. bit 0 of the control word
  typedef struct packed {
    logic scopeChip;
    logic tickSlow;
    logic extOn;
    logic irqOn;
    logic resetOn;
    logic enable;
  } ctrl_t;

  typedef struct packed {
    logic restart;
    logic step;
  } strobe_t;

  typedef struct packed {
    logic irq;
    logic ext;
    logic soc;
    logic chip;
  } act_t;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rstN,
  output logic tickOut
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tickOut = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN)               divCnt <= '0;
        else if (divCnt == LAST) divCnt <= '0;
        else                     divCnt <= divCnt + 1'b1;
      end
      assign tickOut = (divCnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int DIV = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [3:0]       busAddr,
  input  logic [REG_W-1:0] busWdata,
  input  logic [REG_W-1:0] countVal,
  output logic [REG_W-1:0] busRdata,
  output logic [REG_W-1:0] reloadVal,
  output strobe_t          strobe,
  output act_t             actSel,
  output ctrl_t            ctrlVal
);
  ctrl_t          ctrlQ;
  logic [REG_W-1:0] reloadQ;
  reg_sel_e       regSel;
  logic           wrEn;
  logic           slowTick;

  assign regSel = reg_sel_e'(busAddr[3:2]);
  assign wrEn   = busSel && busWrite;

  wdog_prescale #(.DIV(DIV)) u_prescale (
    .clk    (clk),
    .rstN   (rstN),
    .tickOut(slowTick)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ   <= '0;
      reloadQ <= '0;
    end else if (wrEn) begin
      if (regSel == REG_CTRL)   ctrlQ   <= ctrl_t'(busWdata[5:0]);
      if (regSel == REG_RELOAD) reloadQ <= busWdata;
    end
  end

  always_comb begin
    strobe.restart = wrEn && (regSel == REG_RESTART) && (busWdata == RESTART_KEY);
    strobe.step    = ctrlQ.enable && (ctrlQ.tickSlow ? slowTick : 1'b1);
  end

  always_comb begin
    actSel.irq  = ctrlQ.irqOn;
    actSel.ext  = ctrlQ.extOn;
    actSel.soc  = ctrlQ.resetOn && !ctrlQ.scopeChip;
    actSel.chip = ctrlQ.resetOn &&  ctrlQ.scopeChip;
  end

  always_comb begin
    unique case (regSel)
      REG_STATUS:  busRdata = countVal;
      REG_RELOAD:  busRdata = reloadQ;
      REG_RESTART: busRdata = '0;
      REG_CTRL:    busRdata = {{(REG_W-6){1'b0}}, ctrlQ};
      default:     busRdata = '0;
    endcase
  end

  assign reloadVal = reloadQ;
  assign ctrlVal   = ctrlQ;
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int PULSE_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [REG_W-1:0] reloadVal,
  input  act_t             actSel,
  output logic [REG_W-1:0] countVal,
  output logic             expire,
  output act_t             actOut
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);
  localparam logic [PW-1:0] PULSE_LOAD = PW'(PULSE_CYCLES);

  logic [REG_W-1:0] countQ;
  logic [PW-1:0]    pulseCnt;
  act_t             heldSel;

  assign expire = strobe.step && !strobe.restart && (countQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN)                countQ <= '0;
    else if (strobe.restart)  countQ <= reloadVal;
    else if (strobe.step) begin
      if (countQ == '0)       countQ <= reloadVal;
      else                    countQ <= countQ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseCnt <= '0;
      heldSel  <= '0;
    end else if (expire) begin
      pulseCnt <= PULSE_LOAD;
      heldSel  <= actSel;
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign actOut   = (pulseCnt != '0) ? heldSel : '0;
  assign countVal = countQ;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CLK_HZ       = 4_000_000,
  parameter int TICK_HZ      = 1_000_000,
  parameter int PULSE_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [3:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        irqOut,
  output logic        extPulseOut,
  output logic        socResetOut,
  output logic        chipResetOut
);
  localparam int DIV = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ;

  strobe_t          strobe;
  logic [REG_W-1:0] countVal;
  logic [REG_W-1:0] reloadVal;
  act_t             actSel;
  act_t             actOut;
  ctrl_t            ctrlVal;
  logic             expire;

  wdog_ctrl #(.DIV(DIV)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .countVal (countVal),
    .busRdata (busRdata),
    .reloadVal(reloadVal),
    .strobe   (strobe),
    .actSel   (actSel),
    .ctrlVal  (ctrlVal)
  );

  wdog_datapath #(.PULSE_CYCLES(PULSE_CYCLES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reloadVal(reloadVal),
    .actSel   (actSel),
    .countVal (countVal),
    .expire   (expire),
    .actOut   (actOut)
  );

  assign irqOut       = actOut.irq;
  assign extPulseOut  = actOut.ext;
  assign socResetOut  = actOut.soc;
  assign chipResetOut = actOut.chip;
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker (
  input logic        clk,
  input logic        rstN,
  input logic        busSel,
  input logic        busWrite,
  input logic [3:0]  busAddr,
  input logic [31:0] busWdata,
  input logic [31:0] countVal,
  input logic [31:0] reloadVal,
  input logic        enableQ,
  input logic        expire,
  input logic        irqOut,
  input logic        extPulseOut,
  input logic        socResetOut,
  input logic        chipResetOut
);
  logic keyWr, badKeyWr, reloadWr;
  assign keyWr    = busSel && busWrite && busAddr[3:2] == 2'd2 && busWdata == 32'h0000_4755;
  assign badKeyWr = busSel && busWrite && busAddr[3:2] == 2'd2 && busWdata != 32'h0000_4755;
  assign reloadWr = busSel && busWrite && busAddr[3:2] == 2'd1;

  a_r2_key_loads: assert property (@(posedge clk) disable iff (!rstN)
    keyWr |=> countVal == $past(reloadVal));

  a_r3_bad_key_ignored: assert property (@(posedge clk) disable iff (!rstN)
    badKeyWr && !enableQ |=> $stable(countVal));

  a_r4_reload_only: assert property (@(posedge clk) disable iff (!rstN)
    reloadWr && !enableQ |=> $stable(countVal));

  a_r5_hold_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enableQ && !keyWr |=> $stable(countVal));

  a_r8_irq_after_expiry: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(expire));

  a_r8_reset_after_expiry: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(socResetOut) || $rose(chipResetOut)) |-> $past(expire));

  a_r9_scope_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(socResetOut && chipResetOut));
endmodule

bind wdog_timer wdog_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busSel      (busSel),
  .busWrite    (busWrite),
  .busAddr     (busAddr),
  .busWdata    (busWdata),
  .countVal    (countVal),
  .reloadVal   (reloadVal),
  .enableQ     (ctrlVal.enable),
  .expire      (expire),
  .irqOut      (irqOut),
  .extPulseOut (extPulseOut),
  .socResetOut (socResetOut),
  .chipResetOut(chipResetOut)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 4_000_000;
  localparam int TICK_HZ = 1_000_000;
  localparam int DIV = CLK_HZ / TICK_HZ;
  localparam int PULSE = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 1'b0, busWrite = 1'b0;
  logic [3:0] busAddr = 4'h0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic irqOut, extPulseOut, socResetOut, chipResetOut;

  int tests = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_timer #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .PULSE_CYCLES(PULSE)) u_wdog_timer (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .extPulseOut(extPulseOut),
    .socResetOut(socResetOut), .chipResetOut(chipResetOut)
  );

  // behavioural reference model
  logic [31:0] mCount, mReload;
  logic [5:0]  mCtrl;
  int          mPre, mPulse;
  bit          mIrq, mExt, mSoc, mChip;
  int          expiries = 0;

  always @(posedge clk) begin
    bit tick, step, key, exp;
    if (!rstN) begin
      mCount = 0; mReload = 0; mCtrl = 0; mPre = 0; mPulse = 0;
      mIrq = 0; mExt = 0; mSoc = 0; mChip = 0;
    end else begin
      tick = (mPre == DIV - 1);
      step = mCtrl[0] && (mCtrl[4] ? tick : 1'b1);
      key  = busSel && busWrite && busAddr[3:2] == 2 && busWdata == 32'h4755;
      exp  = 0;
      if (key) mCount = mReload;
      else if (step) begin
        if (mCount == 0) begin exp = 1; mCount = mReload; end
        else mCount = mCount - 1;
      end
      if (exp) begin
        expiries++;
        mPulse = PULSE;
        mIrq = mCtrl[2]; mExt = mCtrl[3];
        mSoc = mCtrl[1] && !mCtrl[5]; mChip = mCtrl[1] && mCtrl[5];
      end else if (mPulse > 0) mPulse--;
      if (busSel && busWrite && busAddr[3:2] == 1) mReload = busWdata;
      if (busSel && busWrite && busAddr[3:2] == 3) mCtrl = busWdata[5:0];
      mPre = tick ? 0 : mPre + 1;
    end
  end

  function automatic logic [31:0] expRd();
    case (busAddr[3:2])
      2'd0: return mCount;
      2'd1: return mReload;
      2'd2: return 32'h0;
      default: return {26'h0, mCtrl};
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(busRdata == expRd(), "R1/R2/R4/R5/R6/R7 rdata", busRdata, expRd());
      check(irqOut == (mPulse > 0 && mIrq), "R8 irq", 32'(irqOut), 32'(mPulse > 0 && mIrq));
      check(extPulseOut == (mPulse > 0 && mExt), "R8 ext", 32'(extPulseOut), 32'(mPulse > 0 && mExt));
      check(socResetOut == (mPulse > 0 && mSoc), "R9 soc", 32'(socResetOut), 32'(mPulse > 0 && mSoc));
      check(chipResetOut == (mPulse > 0 && mChip), "R9 chip", 32'(chipResetOut), 32'(mPulse > 0 && mChip));
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWrite = 0; busAddr = 4'h0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic readChk(input logic [3:0] a, input logic [31:0] e, input string req);
    @(posedge clk); #1;
    busSel = 1; busWrite = 0; busAddr = a;
    #2;
    check(busRdata == e, req, busRdata, e);
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int e0;
    bit sawAct;
    idle(3);
    rstN = 1;
    // R10 reset state
    #1;
    check(irqOut == 0 && extPulseOut == 0 && socResetOut == 0 && chipResetOut == 0,
          "R10 outputs", {irqOut, extPulseOut, socResetOut, chipResetOut}, 0);
    readChk(4'h0, 0, "R10 count");
    readChk(4'h4, 0, "R10 reload");
    readChk(4'hC, 0, "R10 ctrl");

    wr(4'h4, 32'd20);
    readChk(4'h4, 32'd20, "R1 reload readback");
    wr(4'h8, 32'h0000_4756);
    readChk(4'h0, 0, "R3 bad key ignored");
    wr(4'h8, 32'h0001_4755);
    readChk(4'h0, 0, "R3 upper bits nonzero ignored");
    wr(4'h8, 32'h0000_4755);
    readChk(4'h0, 32'd20, "R2 key loads count");
    readChk(4'h8, 0, "R1 restart reads zero");

    // R6 bus-clock stepping with irq, ext, soc reset
    wr(4'hC, 32'h0F);
    readChk(4'hC, 32'h0F, "R1 ctrl readback");
    e0 = expiries;
    idle(40);
    check(expiries > e0, "R7 expiry seen", expiries, e0 + 1);

    // R4 reload write alone
    wr(4'hC, 32'h00);
    idle(2);
    busAddr = 4'h0; #1;
    e0 = busRdata;
    wr(4'h4, 32'd5);
    readChk(4'h0, e0, "R4 count unchanged by reload write");
    idle(5);
    readChk(4'h0, e0, "R5 hold while disabled");

    // R6/R9 prescaled stepping, chip scope
    wr(4'h8, 32'h0000_4755);
    wr(4'hC, 32'h3F);
    idle(60);
    // interrupt only
    wr(4'h4, 32'd2);
    wr(4'hC, 32'h05);
    idle(30);
    wr(4'hC, 32'h25);
    idle(30);

    // keep-alive: restarts closer than timeout
    wr(4'hC, 32'h00);
    wr(4'h4, 32'd10);
    wr(4'h8, 32'h0000_4755);
    idle(PULSE + 2);
    wr(4'hC, 32'h0F);
    sawAct = 0;
    for (int k = 0; k < 8; k++) begin
      wr(4'h8, 32'h0000_4755);
      idle(3);
      if (irqOut || socResetOut || extPulseOut) sawAct = 1;
    end
    check(!sawAct, "R2 keep-alive prevents expiry", sawAct, 0);
    wr(4'hC, 32'h00);
    idle(PULSE + 2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule